// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block turns pairs of 18-bit two's-complement audio samples into a three-wire serial stream: a bit clock, a word select that marks the left and right halves of each frame, and one data line. It runs from a system clock at 256 times the sample rate, which is nominally 12.288 MHz for 48 kHz. Samples arrive on a parallel left/right bus with a one-cycle valid strobe. The most recent pair is moved into the transmit registers at the start of each frame, so the two channels of one pair always leave together.

In master mode the block makes the bit clock and word select itself. The bit clock is the system clock divided by four, which gives 64 bit periods per frame and a 32-bit slot per channel. In slave mode it follows an external bit clock and word select, brought into the system-clock domain through a two-flop synchronizer. Each detected word-select transition restarts the slot. One input picks a left-justified layout or a layout delayed by one bit. A further input, honoured only in slave mode, picks a right-justified layout.

A standby input, active low, takes the block off the serial lines. A separate overload flag rises when either channel comes within about 1 dB of full scale. It then stays high for a long, fixed hold time, and a new hit restarts that time.

Top module: `stereo_ser_tx`

## Requirements
- R1: In master mode with `standbyN` high, `bclkOut` is the system clock divided by 4: low for two cycles, then high for two. `wsOut` changes only on a falling edge of `bclkOut` and flips every 32 bit periods, so a frame is 64 bit periods. `bclkOe` and `wsOe` are high.
- R2: In master mode, `sdoOut` changes only on a falling edge of `bclkOut` and holds steady while `bclkOut` is high.
- R3: With `fmtSel` = 1 (left-justified), word select is HIGH for the left channel. The sample MSB is sent in slot position 0, which is the bit period that starts at the word-select edge. The 18 bits follow MSB first, and zeros fill the slot up to position 31.
- R4: With `fmtSel` = 0 and the right-justified layout not selected, word select is LOW for the left channel. The MSB is sent at slot position 1, one bit period after the word-select edge, and zeros fill the rest of the slot.
- R5: With `slaveMode` = 1, `bclkOe` and `wsOe` are low and framing follows `bclkIn` and `wsIn`. The slot position advances on each falling edge of `bclkIn` and returns to 0 on every `wsIn` transition. `sdoOut` takes its new value within 4 system-clock cycles of a falling edge of `bclkIn`.
- R6: With `slaveMode` = 1 and `extFmt` = 1, the layout is right-justified: word select is LOW for the left channel, the MSB is at slot position 14 and the LSB at position 31. In master mode `extFmt` has no effect.
- R7: A pair written with `sampleValid` is sent starting at the next frame's left slot. If several pairs are written before that point, only the last one is sent.
- R8: When `sampleValid` is high, the standby input is high and either sample's magnitude is at least 0x1C852 (-131072 counts as magnitude 131072), `ovld` is high from the next cycle for `OVL_HOLD` cycles (default 131072). A hit during the hold period restarts it. Magnitudes below 0x1C852 do not set `ovld`.
- R9: While `standbyN` is low, `sdoEn`, `bclkOe`, `wsOe` and `ovld` are low, the overload hold is cleared, and overload hits are ignored.
- R10: During and straight after reset, `ovld` and `bclkOut` are low, and `sdoEn` follows `standbyN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 times the sample rate |
| rstN | input | 1 | Asynchronous reset, active low |
| standbyN | input | 1 | Low selects standby |
| slaveMode | input | 1 | High: follow external bit clock and word select |
| fmtSel | input | 1 | High: left-justified layout; low: one-bit-delayed layout |
| extFmt | input | 1 | Slave mode only: high selects the right-justified layout |
| sampleL | input | 18 | Left sample, two's complement |
| sampleR | input | 18 | Right sample, two's complement |
| sampleValid | input | 1 | One-cycle strobe that writes the sample pair |
| bclkIn | input | 1 | External bit clock (slave mode) |
| wsIn | input | 1 | External word select (slave mode) |
| bclkOut | output | 1 | Generated bit clock (master mode) |
| bclkOe | output | 1 | Drive enable for the bit clock pin |
| wsOut | output | 1 | Generated word select (master mode) |
| wsOe | output | 1 | Drive enable for the word select pin |
| sdoOut | output | 1 | Serial data |
| sdoEn | output | 1 | Drive enable for serial data; low means high impedance |
| ovld | output | 1 | Near-full-scale overload flag |

## Verification
A wrong slot position or channel bit shows up in the very next bit period as a shifted or swapped word on `sdoOut`, so comparing whole 32-bit slots catches an offset error of one position within one frame (256 cycles). A wrong transfer from the holding registers into the transmit registers shows as stale or mixed data in the first frame after a write. A wrong synchronizer depth or edge detector in slave mode moves the data change past the 4-cycle window, so the bench sees it at the first sampled bit. A wrong overload counter load or decrement changes the measured high time of `ovld` by whole cycles, which is seen when the flag falls.

// File: rtl/aserial_pkg.sv
package aserial_pkg;
  // One channel slot in the serial frame; a power of two so the master divider wraps cleanly
  parameter int SLOT_BITS = 32;
  localparam int POS_BITS = $clog2(SLOT_BITS);

  typedef enum logic [1:0] {
    FMT_LEFT    = 2'd0,  // MSB in the bit period that starts at the word-select edge
    FMT_DELAYED = 2'd1,  // MSB one bit period after the word-select edge
    FMT_RIGHT   = 2'd2   // LSB in the last bit period of the slot
  } fmt_e;

  // Strobes and state handed from framing control to the datapath
  typedef struct packed {
    logic                load;  // move held pair into transmit registers
    logic                chan;  // 0 = left slot, 1 = right slot
    logic [POS_BITS-1:0] pos;   // bit period inside the current slot
    fmt_e                fmt;
  } ctlStrobe_t;
endpackage

// File: rtl/aserial_sync.sv
module aserial_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[g] <= '0;
          else       stg[g] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[g] <= '0;
          else       stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/aserial_ctl.sv
module aserial_ctl
  import aserial_pkg::*;
#(
  parameter int DIV_LOG2    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       standbyN,
  input  logic       slaveMode,
  input  logic       fmtSel,
  input  logic       extFmt,
  input  logic       bclkIn,
  input  logic       wsIn,
  output logic       bclkOut,
  output logic       wsOut,
  output ctlStrobe_t stb
);
  localparam int CNT_W = DIV_LOG2 + POS_BITS + 1;

  // Format decode; the right-justified layout exists only in slave mode
  fmt_e fmt;
  logic leftHigh;
  always_comb begin
    if (slaveMode && extFmt) fmt = FMT_RIGHT;
    else if (fmtSel)         fmt = FMT_LEFT;
    else                     fmt = FMT_DELAYED;
  end
  assign leftHigh = (fmt == FMT_LEFT);

  logic masterRun, slaveRun;
  assign masterRun = standbyN && !slaveMode;
  assign slaveRun  = standbyN && slaveMode;

  // Master framing: one counter gives divider phase, slot position and channel
  logic [CNT_W-1:0] mCnt, mNext;
  logic mWrap;
  assign mNext = mCnt + 1'b1;
  assign mWrap = masterRun && (mNext == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mCnt <= '0;
    else       mCnt <= masterRun ? mNext : '0;
  end

  assign bclkOut = mCnt[DIV_LOG2-1];
  assign wsOut   = mCnt[CNT_W-1] ^ leftHigh;

  // Slave framing: synchronize the external lines, then detect bit clock falls
  logic [1:0] syncOut;
  logic wsS, bclkS;
  aserial_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({wsIn, bclkIn}),
    .dout (syncOut)
  );
  assign wsS   = syncOut[1];
  assign bclkS = syncOut[0];

  logic bclkPrev, wsLast, sChan;
  logic [POS_BITS-1:0] sPos;
  logic sFall, wsEdge, newChan;
  assign sFall   = slaveRun && bclkPrev && !bclkS;
  assign wsEdge  = sFall && (wsS != wsLast);
  assign newChan = (wsS != leftHigh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkPrev <= 1'b0;
      wsLast   <= 1'b0;
      sChan    <= 1'b0;
      sPos     <= '0;
    end else if (!slaveRun) begin
      bclkPrev <= 1'b0;
      wsLast   <= 1'b0;
      sChan    <= 1'b0;
      sPos     <= '0;
    end else begin
      bclkPrev <= bclkS;
      if (sFall) begin
        wsLast <= wsS;
        if (wsEdge) begin
          sPos  <= '0;
          sChan <= newChan;
        end else if (sPos != '1) begin
          sPos <= sPos + 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb.load = mWrap || (wsEdge && !newChan);
    stb.chan = slaveMode ? sChan : mCnt[CNT_W-1];
    stb.pos  = slaveMode ? sPos  : mCnt[DIV_LOG2 +: POS_BITS];
    stb.fmt  = fmt;
  end

  // R1: generated word select moves only together with a bit clock fall
  p_ws_on_fall_r1: assert property (@(posedge clk) disable iff (!rstN)
    (masterRun && $past(masterRun) && $stable(fmtSel) && !$stable(wsOut))
      |-> ($past(bclkOut) && !bclkOut));

  // R5: in slave mode the slot position only steps by one or restarts at zero
  p_pos_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (slaveRun && $past(slaveRun) && !$stable(sPos))
      |-> (sPos == '0 || sPos == $past(sPos) + 1'b1));

  // R7: a transfer into the transmit registers always opens a left slot at position 0
  p_load_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> ((stb.pos == '0 && !stb.chan) || !$stable(slaveMode)));
endmodule

// File: rtl/aserial_dp.sv
module aserial_dp
  import aserial_pkg::*;
#(
  parameter int DATA_W    = 18,
  parameter int OVL_HOLD  = 131072,
  parameter int OVL_LEVEL = 32'h1C852
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standbyN,
  input  ctlStrobe_t        stb,
  input  logic [DATA_W-1:0] sampleL,
  input  logic [DATA_W-1:0] sampleR,
  input  logic              sampleValid,
  output logic              sdoOut,
  output logic              sdoEn,
  output logic              ovld
);
  localparam int HOLD_W  = $clog2(OVL_HOLD + 1);
  localparam int RJ_OFFS = SLOT_BITS - DATA_W;
  localparam logic [DATA_W:0] LEVEL = (DATA_W + 1)'(OVL_LEVEL);

  // Holding registers take every write; transmit registers change only at frame start
  logic [DATA_W-1:0] holdL, holdR, txL, txR;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdL <= '0;
      holdR <= '0;
    end else if (sampleValid) begin
      holdL <= sampleL;
      holdR <= sampleR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txL <= '0;
      txR <= '0;
    end else if (stb.load) begin
      txL <= holdL;
      txR <= holdR;
    end
  end

  // Bit select: slot position minus the layout offset picks a bit, MSB first
  logic [POS_BITS:0]   offs, posX, rel;
  logic [DATA_W-1:0]   word, shifted;
  logic                inWin;
  always_comb begin
    case (stb.fmt)
      FMT_LEFT:    offs = '0;
      FMT_DELAYED: offs = (POS_BITS + 1)'(1);
      FMT_RIGHT:   offs = (POS_BITS + 1)'(RJ_OFFS);
      default:     offs = '0;
    endcase
    posX    = {1'b0, stb.pos};
    rel     = posX - offs;
    inWin   = (posX >= offs) && (rel < (POS_BITS + 1)'(DATA_W));
    word    = stb.chan ? txR : txL;
    shifted = word << rel;
    sdoOut  = inWin & shifted[DATA_W-1];
  end

  assign sdoEn = standbyN;

  // Overload detect on the magnitude, one bit wider so the most negative code fits
  function automatic logic [DATA_W:0] magOf(input logic [DATA_W-1:0] x);
    return x[DATA_W-1] ? ({1'b0, ~x} + 1'b1) : {1'b0, x};
  endfunction

  logic ovHit;
  assign ovHit = sampleValid && standbyN &&
                 ((magOf(sampleL) >= LEVEL) || (magOf(sampleR) >= LEVEL));

  logic [HOLD_W-1:0] ovlCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ovlCnt <= '0;
    else if (!standbyN)       ovlCnt <= '0;
    else if (ovHit)           ovlCnt <= HOLD_W'(OVL_HOLD);
    else if (ovlCnt != '0)    ovlCnt <= ovlCnt - 1'b1;
  end

  assign ovld = standbyN && (ovlCnt != '0);

  // R8: a hit raises the flag on the next cycle unless standby intervenes
  p_ovl_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovHit |=> (ovld || !standbyN));

  // R8: the flag only drops after the hold count has run down to its last cycle
  p_ovl_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ovld) && standbyN) |-> ($past(ovlCnt) == HOLD_W'(1)));

  // R9: standby keeps the flag and the data drive low
  p_stdby_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!standbyN && !$past(standbyN)) |-> (!ovld && !sdoEn && ovlCnt == '0));
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
  import aserial_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int DIV_LOG2    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int OVL_HOLD    = 131072,
  parameter int OVL_LEVEL   = 32'h1C852
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standbyN,
  input  logic              slaveMode,
  input  logic              fmtSel,
  input  logic              extFmt,
  input  logic [DATA_W-1:0] sampleL,
  input  logic [DATA_W-1:0] sampleR,
  input  logic              sampleValid,
  input  logic              bclkIn,
  input  logic              wsIn,
  output logic              bclkOut,
  output logic              bclkOe,
  output logic              wsOut,
  output logic              wsOe,
  output logic              sdoOut,
  output logic              sdoEn,
  output logic              ovld
);
  ctlStrobe_t stb;

  aserial_ctl #(.DIV_LOG2(DIV_LOG2), .SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .standbyN  (standbyN),
    .slaveMode (slaveMode),
    .fmtSel    (fmtSel),
    .extFmt    (extFmt),
    .bclkIn    (bclkIn),
    .wsIn      (wsIn),
    .bclkOut   (bclkOut),
    .wsOut     (wsOut),
    .stb       (stb)
  );

  aserial_dp #(.DATA_W(DATA_W), .OVL_HOLD(OVL_HOLD), .OVL_LEVEL(OVL_LEVEL)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .standbyN    (standbyN),
    .stb         (stb),
    .sampleL     (sampleL),
    .sampleR     (sampleR),
    .sampleValid (sampleValid),
    .sdoOut      (sdoOut),
    .sdoEn       (sdoEn),
    .ovld        (ovld)
  );

  // Clock and word select pins are driven only as master and out of standby
  assign bclkOe = standbyN && !slaveMode;
  assign wsOe   = standbyN && !slaveMode;

  // R2: in master mode the data line moves only with a bit clock fall
  p_sdo_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && standbyN && $past(!slaveMode && standbyN) && $stable(fmtSel)
      && !$stable(sdoOut)) |-> $fell(bclkOut));
endmodule

// File: tb/sim_stereo_ser_tx.sv
module sim_stereo_ser_tx;
  localparam int HOLD = 300;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standbyN = 1'b1, slaveMode = 1'b0, fmtSel = 1'b1, extFmt = 1'b0;
  logic [17:0] sampleL = '0, sampleR = '0;
  logic sampleValid = 1'b0;
  logic bclkIn = 1'b1, wsIn = 1'b1;
  logic bclkOut, bclkOe, wsOut, wsOe, sdoOut, sdoEn, ovld;

  int nChk = 0;
  int nErr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stereo_ser_tx #(.OVL_HOLD(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .standbyN(standbyN), .slaveMode(slaveMode),
    .fmtSel(fmtSel), .extFmt(extFmt), .sampleL(sampleL), .sampleR(sampleR),
    .sampleValid(sampleValid), .bclkIn(bclkIn), .wsIn(wsIn),
    .bclkOut(bclkOut), .bclkOe(bclkOe), .wsOut(wsOut), .wsOe(wsOe),
    .sdoOut(sdoOut), .sdoEn(sdoEn), .ovld(ovld)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expSlot(input logic [17:0] w, input int offs);
    return {w, 14'b0} >> offs;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  endtask

  task automatic setSample(input logic [17:0] l, input logic [17:0] r);
    @(negedge clk);
    sampleL = l; sampleR = r; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // Master capture: wait for a word-select edge to the left level, then take 64 bits at bit clock rises
  task automatic capMaster(input logic leftLvl, output logic [31:0] cl, output logic [31:0] cr,
                           output int clkErr, output int stabErr);
    logic pw, pb, ps;
    int pos, n, lastRise;
    bit found;
    cl = '0; cr = '0; clkErr = 0; stabErr = 0;
    repeat (2) @(negedge clk);
    pw = wsOut; found = 0;
    while (!found) begin
      @(negedge clk);
      if (wsOut != pw && wsOut == leftLvl) found = 1;
      pw = wsOut;
    end
    pb = bclkOut; ps = sdoOut; pos = 0; n = 0; lastRise = -1;
    while (pos < 64) begin
      @(negedge clk);
      n++;
      if (bclkOut && pb && sdoOut != ps) stabErr++;
      if (bclkOut && !pb) begin
        if (lastRise >= 0 && (n - lastRise) != 4) clkErr++;
        lastRise = n;
        if (pos < 32) begin
          cl[31-pos] = sdoOut;
          if (wsOut != leftLvl) clkErr++;
        end else begin
          cr[63-pos] = sdoOut;
          if (wsOut == leftLvl) clkErr++;
        end
        pos++;
      end
      pb = bclkOut; ps = sdoOut;
    end
  endtask

  // Slave frame: bench drives an 8-cycle bit clock and samples data just before each rise
  task automatic slaveFrame(input logic leftLvl, output logic [31:0] cl, output logic [31:0] cr);
    cl = '0; cr = '0;
    for (int ch = 0; ch < 2; ch++) begin
      for (int b = 0; b < 32; b++) begin
        @(negedge clk);
        bclkIn = 1'b0;
        if (b == 0) wsIn = (ch == 0) ? leftLvl : ~leftLvl;
        repeat (4) @(negedge clk);
        if (ch == 0) cl[31-b] = sdoOut; else cr[31-b] = sdoOut;
        bclkIn = 1'b1;
        repeat (3) @(negedge clk);
      end
    end
  endtask

  task automatic tReset();
    chk("R10", "ovld in reset", 64'(ovld), 64'd0);
    chk("R10", "bclkOut in reset", 64'(bclkOut), 64'd0);
    chk("R10", "sdoEn in reset", 64'(sdoEn), 64'd1);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R10", "ovld after reset", 64'(ovld), 64'd0);
    chk("R1", "bclkOe master", 64'(bclkOe), 64'd1);
    chk("R1", "wsOe master", 64'(wsOe), 64'd1);
  endtask

  task automatic tMasterLeft();
    logic [31:0] cl, cr; int ce, se;
    fmtSel = 1'b1; extFmt = 1'b0;
    setSample(18'h2A5A5, 18'h15A5A);
    capMaster(1'b1, cl, cr, ce, se);
    chk("R3", "left-justified left slot", 64'(cl), 64'(expSlot(18'h2A5A5, 0)));
    chk("R3", "left-justified right slot", 64'(cr), 64'(expSlot(18'h15A5A, 0)));
    chk("R1", "bit clock period and word select span", 64'(ce), 64'd0);
    chk("R2", "data steady while bit clock high", 64'(se), 64'd0);
  endtask

  task automatic tMasterDelayed();
    logic [31:0] cl, cr; int ce, se;
    fmtSel = 1'b0; extFmt = 1'b0;
    setSample(18'h11111, 18'h22222);
    setSample(18'h3FFFF, 18'h00001);   // R7: this later pair must win
    capMaster(1'b0, cl, cr, ce, se);
    chk("R4", "delayed layout left slot", 64'(cl), 64'(expSlot(18'h3FFFF, 1)));
    chk("R7", "last written pair sent (right)", 64'(cr), 64'(expSlot(18'h00001, 1)));
    chk("R1", "bit clock in delayed layout", 64'(ce), 64'd0);
    chk("R2", "data steady in delayed layout", 64'(se), 64'd0);
  endtask

  task automatic tMasterExtIgnored();
    logic [31:0] cl, cr; int ce, se;
    fmtSel = 1'b0; extFmt = 1'b1;
    setSample(18'h0F0F3, 18'h30C0C);
    capMaster(1'b0, cl, cr, ce, se);
    chk("R6", "extFmt ignored in master (left)", 64'(cl), 64'(expSlot(18'h0F0F3, 1)));
    chk("R6", "extFmt ignored in master (right)", 64'(cr), 64'(expSlot(18'h30C0C, 1)));
    extFmt = 1'b0;
  endtask

  task automatic tSlave();
    logic [31:0] cl, cr;
    @(negedge clk);
    slaveMode = 1'b1; fmtSel = 1'b0; extFmt = 1'b0;
    bclkIn = 1'b1; wsIn = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5", "bclkOe in slave", 64'(bclkOe), 64'd0);
    chk("R5", "wsOe in slave", 64'(wsOe), 64'd0);
    setSample(18'h1ABCD, 18'h2468A);
    slaveFrame(1'b0, cl, cr);
    slaveFrame(1'b0, cl, cr);
    chk("R5", "slave delayed layout left", 64'(cl), 64'(expSlot(18'h1ABCD, 1)));
    chk("R5", "slave delayed layout right", 64'(cr), 64'(expSlot(18'h2468A, 1)));
    extFmt = 1'b1;
    setSample(18'h12345, 18'h3C00F);
    slaveFrame(1'b0, cl, cr);
    slaveFrame(1'b0, cl, cr);
    chk("R6", "slave right-justified left", 64'(cl), 64'(expSlot(18'h12345, 14)));
    chk("R6", "slave right-justified right", 64'(cr), 64'(expSlot(18'h3C00F, 14)));
    @(negedge clk);
    extFmt = 1'b0; slaveMode = 1'b0; fmtSel = 1'b1;
  endtask

  task automatic tOverload();
    int n;
    setSample(18'h1C851, 18'h00000);
    chk("R8", "just below level, positive", 64'(ovld), 64'd0);
    setSample(18'h00000, (~18'h1C851) + 18'd1);
    chk("R8", "just below level, negative", 64'(ovld), 64'd0);
    setSample(18'h1C852, 18'h00000);
    n = 0;
    while (ovld && n < 4 * HOLD) begin n++; @(negedge clk); end
    chk("R8", "hold length after hit", 64'(n), 64'(HOLD));
    setSample(18'h00000, (~18'h1C852) + 18'd1);
    repeat (100) @(negedge clk);
    chk("R8", "still high mid-hold", 64'(ovld), 64'd1);
    setSample(18'h00000, (~18'h1C852) + 18'd1);
    n = 0;
    while (ovld && n < 4 * HOLD) begin n++; @(negedge clk); end
    chk("R8", "hold restarts on new hit", 64'(n), 64'(HOLD));
    setSample(18'h20000, 18'h00000);
    chk("R8", "most negative code hits", 64'(ovld), 64'd1);
  endtask

  task automatic tStandby();
    @(negedge clk);
    standbyN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "sdoEn in standby", 64'(sdoEn), 64'd0);
    chk("R9", "bclkOe in standby", 64'(bclkOe), 64'd0);
    chk("R9", "wsOe in standby", 64'(wsOe), 64'd0);
    chk("R9", "ovld forced low", 64'(ovld), 64'd0);
    setSample(18'h1FFFF, 18'h1FFFF);
    chk("R9", "hit ignored in standby", 64'(ovld), 64'd0);
    standbyN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "no leftover hold after standby", 64'(ovld), 64'd0);
    chk("R9", "sdoEn back after standby", 64'(sdoEn), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    tMasterLeft();
    tMasterDelayed();
    tMasterExtIgnored();
    tSlave();
    tOverload();
    tStandby();
    finishRun();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    finishRun();
  end
endmodule